// File: doc/BRIEF.md
# Serial Statistics Vector Link

This block moves a 32-bit per-frame transmit statistics word across a single data wire. A one-bit valid wire qualifies the data. The sending half sits in the transmitter. When a one-cycle strobe arrives, it captures the word and shifts it out least significant bit first, one bit per clock.

The receiving half sits in user logic on the same clock. It rebuilds the word and gives a one-cycle completion pulse. It drops any word whose valid wire falls early.

A frame-byte activity flag travels beside the serial pair, one bit per clock. The receiver's serial inputs are separate ports, so the two halves are normally joined outside the block. This also lets the receiver be driven on its own.

Top module: `stat_serial_link`

## Requirements
- R1: A strobe sampled at a clock edge makes the serial valid output go high after that edge. It stays high for exactly 32 consecutive cycles for that word.
- R2: Word bits appear on the serial data output in ascending order: bit 0 during the first valid cycle, bit 31 during the 32nd.
- R3: When the receiver samples bit 31 of a word with its valid input high at an edge, the parallel-valid output is high for the single cycle after that edge. The parallel vector then equals the word, with the first received bit in position 0.
- R4: The parallel vector output keeps its value until the next word completes.
- R5: If the receiver's valid input is low at an edge before 32 bits have been collected, the partial word is discarded. The next valid bit is taken as bit 0, and no parallel-valid pulse results from the fragment.
- R6: A strobe sampled at the edge that ends the cycle in which bit 31 is shown starts the new word with no idle cycle. Its bit 0 follows bit 31 directly.
- R7: A strobe that arrives while a word is being sent is held. The held word starts in the cycle right after the current word's bit 31. A later strobe before that start replaces the held word.
- R8: The byte-activity output equals the frame-byte input sampled at the previous clock edge.
- R9: A synchronous active-high reset clears the shift state, the bit counters, any held word and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit client clock shared by both halves |
| rst | input | 1 | Synchronous active-high reset |
| stat_word_i | input | 32 | Statistics word to be sent |
| stat_strobe_i | input | 1 | One-cycle strobe accepting stat_word_i |
| frame_byte_i | input | 1 | High while a frame byte (destination address through FCS) is being transmitted |
| ser_data_o | output | 1 | Serial statistics bit |
| ser_valid_o | output | 1 | Qualifies ser_data_o |
| byte_flag_o | output | 1 | Registered frame-byte activity flag |
| rx_data_i | input | 1 | Serial data into the receiver |
| rx_valid_i | input | 1 | Serial valid into the receiver |
| vec_o | output | 32 | Rebuilt statistics word |
| vec_valid_o | output | 1 | One-cycle pulse when vec_o has just been updated |

## Verification
Every result is due a fixed number of registers after its cause.
- Serial bit k of a word is visible in the k+1-th cycle after the strobe edge.
- The parallel pulse and vector follow the edge that samples bit 31 by one register, which is 33 cycles after the strobe when the halves are looped back.
- The activity flag lags its input by one edge.

The bench drives inputs at the falling edge and advances a behavioural model at the rising edge. It compares every output at the following falling edge, so each expected value is sampled in the first cycle it is due.

// File: rtl/stat_link_pkg.sv
package stat_link_pkg;
  localparam int STAT_W = 32;

  // True when a bit index names the last bit of a word of the given width.
  function automatic logic is_final_bit(input int idx, input int width);
    return idx == width - 1;
  endfunction

  // Index that follows idx within a word, wrapping after the last bit.
  function automatic int next_index(input int idx, input int width);
    return (idx == width - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/stat_ser_tx.sv
module stat_ser_tx
  import stat_link_pkg::*;
#(
  parameter int W = STAT_W,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  input  logic         strobe_i,
  output logic         sdata_o,
  output logic         svalid_o
);
  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic          pend_v;
  logic [W-1:0]  pend_w;

  // named events
  logic last_bit, start_pend, start_new, capture;
  assign last_bit   = busy && is_final_bit(int'(cnt), W);
  assign start_pend = last_bit && pend_v;
  assign start_new  = strobe_i && (!busy || (last_bit && !pend_v));
  assign capture    = strobe_i && !start_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      pend_v <= 1'b0;
      pend_w <= '0;
    end else begin
      if (start_pend) begin
        sh   <= pend_w;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (start_new) begin
        sh   <= word_i;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (last_bit) begin
        sh   <= '0;
        cnt  <= '0;
        busy <= 1'b0;
      end else if (busy) begin
        sh  <= sh >> 1;
        cnt <= CW'(next_index(int'(cnt), W));
      end
      if (capture) begin
        pend_v <= 1'b1;
        pend_w <= word_i;
      end else if (start_pend) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign sdata_o  = busy & sh[0];
  assign svalid_o = busy;

  // R1
  svalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_bit) |=> svalid_o);
  // R1
  svalid_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(svalid_o) |-> $past(strobe_i));
  // R7
  pend_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (last_bit && pend_v) |=> (svalid_o && cnt == '0));
endmodule

// File: rtl/stat_ser_rx.sv
module stat_ser_rx
  import stat_link_pkg::*;
#(
  parameter int W = STAT_W,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdata_i,
  input  logic         svalid_i,
  output logic [W-1:0] vec_o,
  output logic         vec_valid_o
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  acc;
  logic          word_done;

  assign word_done = svalid_i && is_final_bit(int'(cnt), W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      acc         <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= 1'b0;
      if (word_done) begin
        vec_o       <= {sdata_i, acc[W-2:0]};
        vec_valid_o <= 1'b1;
        cnt         <= '0;
        acc         <= '0;
      end else if (svalid_i) begin
        acc[cnt] <= sdata_i;
        cnt      <= CW'(next_index(int'(cnt), W));
      end else begin
        cnt <= '0;
        acc <= '0;
      end
    end
  end

  // R3
  vv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> !vec_valid_o);
  // R3
  vv_source_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(svalid_i));
  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_o |-> $stable(vec_o));
  // R5
  drop_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !svalid_i |=> (cnt == '0 && !vec_valid_o));
endmodule

// File: rtl/stat_byte_flag_stage.sv
module stat_byte_flag_stage (
  input  logic clk,
  input  logic rst,
  input  logic flag_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_i;
  end

  // R8
  flag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flag_o == $past(flag_i)));
endmodule

// File: rtl/stat_serial_link.sv
module stat_serial_link
  import stat_link_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_word_i,
  input  logic         stat_strobe_i,
  input  logic         frame_byte_i,
  output logic         ser_data_o,
  output logic         ser_valid_o,
  output logic         byte_flag_o,
  input  logic         rx_data_i,
  input  logic         rx_valid_i,
  output logic [W-1:0] vec_o,
  output logic         vec_valid_o
);
  stat_ser_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .word_i(stat_word_i), .strobe_i(stat_strobe_i),
    .sdata_o(ser_data_o), .svalid_o(ser_valid_o)
  );

  stat_ser_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .sdata_i(rx_data_i), .svalid_i(rx_valid_i),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  stat_byte_flag_stage u_flag (
    .clk(clk), .rst(rst), .flag_i(frame_byte_i), .flag_o(byte_flag_o)
  );

  // R9
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!ser_valid_o && !vec_valid_o && !byte_flag_o));
endmodule

// File: tb/stat_serial_link_tb.sv
module stat_serial_link_tb;
  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] word = '0;
  logic        strobe = 1'b0;
  logic        fb = 1'b0;
  logic        loop = 1'b1;
  logic        man_d = 1'b0;
  logic        man_v = 1'b0;
  logic        ser_data, ser_valid, byte_flag, vec_valid;
  logic [31:0] vec;
  logic        rx_d, rx_v;

  assign rx_d = loop ? ser_data  : man_d;
  assign rx_v = loop ? ser_valid : man_v;

  stat_serial_link u_dut (
    .clk(clk), .rst(rst), .stat_word_i(word), .stat_strobe_i(strobe),
    .frame_byte_i(fb), .ser_data_o(ser_data), .ser_valid_o(ser_valid),
    .byte_flag_o(byte_flag), .rx_data_i(rx_d), .rx_valid_i(rx_v),
    .vec_o(vec), .vec_valid_o(vec_valid)
  );

  int errors = 0;
  int checks = 0;

  // behavioural model state
  int          tpos = -1;
  logic [31:0] tcur = '0;
  bit          pv = 0;
  logic [31:0] pw = '0;
  int          rn = 0;
  logic [31:0] racc = '0;
  logic [31:0] evec = '0;
  logic        evv = 1'b0;
  logic        ebf = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic [31:0] w,
                     input logic f, input logic md, input logic mv);
    logic rd, rv;
    rst = r; strobe = s; word = w; fb = f; man_d = md; man_v = mv;
    #1;
    rd = rx_d; rv = rx_v;
    @(posedge clk);
    if (r) begin
      tpos = -1; pv = 0; rn = 0; racc = '0; evec = '0; evv = 1'b0; ebf = 1'b0;
    end else begin
      ebf = f;
      evv = 1'b0;
      if (rv) begin
        racc[rn] = rd;
        if (rn == 31) begin
          evec = racc; evv = 1'b1; rn = 0; racc = '0;
        end else rn++;
      end else begin
        rn = 0; racc = '0;
      end
      if (tpos < 0 || tpos == 31) begin
        if (tpos == 31 && pv) begin
          tcur = pw; tpos = 0; pv = 0;
          if (s) begin pv = 1; pw = w; end
        end else if (s) begin
          tcur = w; tpos = 0;
        end else tpos = -1;
      end else begin
        tpos++;
        if (s) begin pv = 1; pw = w; end
      end
    end
    @(negedge clk);
    chk("R1 ser_valid", {31'd0, ser_valid}, {31'd0, tpos >= 0});
    if (tpos >= 0) chk("R2 ser_data", {31'd0, ser_data}, {31'd0, tcur[tpos]});
    chk("R3 vec_valid", {31'd0, vec_valid}, {31'd0, evv});
    chk("R4 vec", vec, evec);
    chk("R8 byte_flag", {31'd0, byte_flag}, {31'd0, ebf});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'($urandom_range(1)), 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // R9: reset state with busy-looking inputs
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    // R1 R2 R3 R8: single word
    cyc(1'b0, 1'b1, 32'hA5C3_0F81, 1'b1, 1'b0, 1'b0);
    idle(40);
    // R6: strobe on the bit-31 cycle, no gap
    cyc(1'b0, 1'b1, 32'h8000_0001, 1'b0, 1'b0, 1'b0);
    idle(31);
    cyc(1'b0, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 1'b0);
    idle(40);
    // R7: strobe while busy is held; later strobe replaces held word
    cyc(1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0);
    idle(10);
    cyc(1'b0, 1'b1, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b0);
    idle(5);
    cyc(1'b0, 1'b1, 32'hC001_D00D, 1'b0, 1'b0, 1'b0);
    idle(80);
    // R5: truncated fragment then a full word on the receiver alone
    loop = 1'b0;
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) cyc(1'b0, 1'b0, '0, 1'b1, 1'((32'h6E0F_3A19 >> i) & 1), 1'b1);
    idle(3);
    loop = 1'b1;
    idle(2);
    // R9: reset mid-word with a held word pending
    cyc(1'b0, 1'b1, 32'hFACE_CAFE, 1'b1, 1'b0, 1'b0);
    idle(10);
    cyc(1'b0, 1'b1, 32'h5555_AAAA, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    idle(45);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule